// File: doc/BRIEF.md
# Scalar Fused Multiply-Add Operand Router with Masked Writeback

This block sits between a vector register file and a scalar single-precision fused multiply-add datapath. Each request carries the current 128-bit value of the destination register (which is also the first source), a 128-bit second source, a 32-bit third source, an opcode byte, and three masking controls. From the opcode byte the block picks one of three operand orderings. It drives the low 32-bit elements onto the datapath's two multiplier inputs and its addend input. The datapath sits outside this block and is combinational, so its result and exception flags come back in the same cycle.

One clock edge after a request, the block presents a full-width register write of 512 bits. The low element holds the computed value, unless masking suppresses it. In that case the low element either keeps its old contents (merging) or is cleared (zeroing). Bits 127:32 come unchanged from the destination, and everything from bit 128 up is cleared. An opcode the block does not support raises an illegal-opcode flag and no write is issued. Exception flags from the datapath are forwarded only when the element was actually computed.

Top module: `fma_route_wb`

## Requirements
- R1: With opcode 0x99 the multiplier inputs are destination[31:0] (port A) and third source[31:0] (port B), and the addend is second source[31:0]. This holds combinationally in the same cycle.
- R2: With opcode 0xA9 the multiplier inputs are second source[31:0] (A) and destination[31:0] (B), and the addend is third source[31:0].
- R3: With opcode 0xB9 the multiplier inputs are second source[31:0] (A) and third source[31:0] (B), and the addend is destination[31:0].
- R4: One cycle after a request with a supported opcode, `out_valid` and `wr_en` are 1. If `mask_en` is 0, or `mask_b0` is 1, `wr_data[31:0]` equals the datapath result sampled with that request. `mask_b0` has no effect while `mask_en` is 0.
- R5: If `mask_en` is 1, `mask_b0` is 0 and `zero_mode` is 0 (merging), `wr_data[31:0]` equals the old destination[31:0].
- R6: If `mask_en` is 1, `mask_b0` is 0 and `zero_mode` is 1 (zeroing), `wr_data[31:0]` is 0.
- R7: On every write, `wr_data[127:32]` equals destination[127:32] of the request.
- R8: `wr_data[511:128]` is always 0.
- R9: Any other opcode drives all three datapath inputs to 0. One cycle later it gives `out_valid`=1, `illegal_op`=1, `wr_en`=0, and all-zero `wr_data` and `exc_flags`.
- R10: `exc_flags` equals the datapath flags sampled with the request only when the low element is computed. Otherwise it is 0.
- R11: While `rst_n` is 0 at a clock edge, `out_valid`, `wr_en`, `illegal_op`, `exc_flags` and `wr_data` are cleared.
- R12: One cycle after a cycle with `in_valid` low, `out_valid`, `wr_en`, `illegal_op`, `exc_flags` and `wr_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| opcode | input | 8 | Operand-form selector byte |
| dst_in | input | 128 | Destination register value, also first source |
| src2_in | input | 128 | Second source register value |
| src3_in | input | 32 | Third source element |
| mask_en | input | 1 | Masking enabled |
| mask_b0 | input | 1 | Mask bit for element 0 |
| zero_mode | input | 1 | 1 = zero masked element, 0 = merge |
| dp_mul_a | output | 32 | Datapath multiplier input A |
| dp_mul_b | output | 32 | Datapath multiplier input B |
| dp_add_c | output | 32 | Datapath addend input |
| dp_result | input | 32 | Datapath rounded result |
| dp_flags | input | 5 | Datapath exception flags |
| out_valid | output | 1 | Writeback slot valid |
| wr_en | output | 1 | Register write enable |
| wr_data | output | 512 | Full-width destination write value |
| illegal_op | output | 1 | Unsupported opcode seen |
| exc_flags | output | 5 | Forwarded exception flags |

## Verification
The operand routing (R1 to R3) is due in the same cycle as the request. The bench samples it after driving on the falling edge and before the next rising edge. Everything on the writeback side (R4 to R10, R12) is due exactly one rising edge after the request. The bench therefore drives each request on a falling edge, lets one rising edge pass, and reads the outputs on the following falling edge. Reset (R11) is checked the same way, one edge after `rst_n` is held low with a request pending.

// File: rtl/fmaw_pkg.sv
// Package: shared types and constants for the scalar FMA router.
// Assumes opcode byte values are fixed by the instruction encoding.
package fmaw_pkg;
    typedef enum logic [1:0] {
        FORM_NONE = 2'd0,
        FORM_132  = 2'd1,
        FORM_213  = 2'd2,
        FORM_231  = 2'd3
    } form_e;

    localparam logic [7:0] OPC_132 = 8'h99;
    localparam logic [7:0] OPC_213 = 8'hA9;
    localparam logic [7:0] OPC_231 = 8'hB9;
endpackage

// File: rtl/fmaw_decode.sv
// Decodes the opcode byte into an operand form and a legality flag.
// Assumes exactly three legal opcode values; all others are illegal.
module fmaw_decode
    import fmaw_pkg::*;
#(
    parameter int OPC_W = 8
) (
    input  logic [OPC_W-1:0] opcode,
    output form_e            form,
    output logic             legal
);
    // Map opcode byte to an operand form.
    always_comb begin
        form  = FORM_NONE;
        legal = 1'b1;
        case (opcode)
            OPC_W'(OPC_132): form = FORM_132;
            OPC_W'(OPC_213): form = FORM_213;
            OPC_W'(OPC_231): form = FORM_231;
            default:         legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/fmaw_route.sv
// Routes the low elements onto the datapath multiplier and adder inputs.
// Assumes FORM_NONE drives all datapath inputs to zero.
module fmaw_route
    import fmaw_pkg::*;
#(
    parameter int ELEM_W = 32
) (
    input  form_e             form,
    input  logic [ELEM_W-1:0] dst_lo,
    input  logic [ELEM_W-1:0] src2_lo,
    input  logic [ELEM_W-1:0] src3_lo,
    output logic [ELEM_W-1:0] mul_a,
    output logic [ELEM_W-1:0] mul_b,
    output logic [ELEM_W-1:0] add_c
);
    // Select the operand ordering for the chosen form.
    always_comb begin
        mul_a = '0;
        mul_b = '0;
        add_c = '0;
        case (form)
            FORM_132: begin
                mul_a = dst_lo;
                mul_b = src3_lo;
                add_c = src2_lo;
            end
            FORM_213: begin
                mul_a = src2_lo;
                mul_b = dst_lo;
                add_c = src3_lo;
            end
            FORM_231: begin
                mul_a = src2_lo;
                mul_b = src3_lo;
                add_c = dst_lo;
            end
            default: begin
                mul_a = '0;
                mul_b = '0;
                add_c = '0;
            end
        endcase
    end
endmodule

// File: rtl/fmaw_merge.sv
// Builds the full-width register write from the datapath result and masks.
// Assumes MAXVL >= REG_W > ELEM_W; all bits above REG_W are written as zero.
module fmaw_merge #(
    parameter int ELEM_W = 32,
    parameter int REG_W  = 128,
    parameter int MAXVL  = 512,
    parameter int FLAG_W = 5
) (
    input  logic              legal,
    input  logic              mask_en,
    input  logic              mask_b0,
    input  logic              zero_mode,
    input  logic [REG_W-1:0]  dst,
    input  logic [ELEM_W-1:0] result,
    input  logic [FLAG_W-1:0] flags_in,
    output logic              wr_en,
    output logic [MAXVL-1:0]  data,
    output logic [FLAG_W-1:0] flags_out
);
    localparam int UPPER_W = MAXVL - REG_W;

    logic              compute;
    logic [ELEM_W-1:0] low_elem;

    // Decide whether element 0 is computed or masked off.
    always_comb compute = legal && (!mask_en || mask_b0);

    // Pick the low element: result, merged old value, or zero.
    always_comb begin
        if (compute)        low_elem = result;
        else if (zero_mode) low_elem = '0;
        else                low_elem = dst[ELEM_W-1:0];
    end

    // Assemble the register-width part; illegal requests produce all zero.
    always_comb begin
        data[REG_W-1:0] = legal ? {dst[REG_W-1:ELEM_W], low_elem} : '0;
    end

    // Clear every bit above the register width.
    generate
        if (UPPER_W > 0) begin : g_upper
            always_comb data[MAXVL-1:REG_W] = '0;
        end
    endgenerate

    // Write enable and flag forwarding.
    always_comb begin
        wr_en     = legal;
        flags_out = compute ? flags_in : '0;
    end
endmodule

// File: rtl/fma_route_wb.sv
// Top: scalar FMA operand router and masked full-width writeback.
// Assumes a combinational external datapath; writeback is registered once,
// so results appear one clock after the request. Synchronous active-low reset.
module fma_route_wb
    import fmaw_pkg::*;
#(
    parameter int OPC_W  = 8,
    parameter int ELEM_W = 32,
    parameter int REG_W  = 128,
    parameter int MAXVL  = 512,
    parameter int FLAG_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [REG_W-1:0]  dst_in,
    input  logic [REG_W-1:0]  src2_in,
    input  logic [ELEM_W-1:0] src3_in,
    input  logic              mask_en,
    input  logic              mask_b0,
    input  logic              zero_mode,
    output logic [ELEM_W-1:0] dp_mul_a,
    output logic [ELEM_W-1:0] dp_mul_b,
    output logic [ELEM_W-1:0] dp_add_c,
    input  logic [ELEM_W-1:0] dp_result,
    input  logic [FLAG_W-1:0] dp_flags,
    output logic              out_valid,
    output logic              wr_en,
    output logic [MAXVL-1:0]  wr_data,
    output logic              illegal_op,
    output logic [FLAG_W-1:0] exc_flags
);
    form_e             form;
    logic              legal;
    logic              wr_en_d;
    logic [MAXVL-1:0]  data_d;
    logic [FLAG_W-1:0] flags_d;

    fmaw_decode #(.OPC_W(OPC_W)) u_decode (
        .opcode (opcode),
        .form   (form),
        .legal  (legal)
    );

    fmaw_route #(.ELEM_W(ELEM_W)) u_route (
        .form    (form),
        .dst_lo  (dst_in[ELEM_W-1:0]),
        .src2_lo (src2_in[ELEM_W-1:0]),
        .src3_lo (src3_in),
        .mul_a   (dp_mul_a),
        .mul_b   (dp_mul_b),
        .add_c   (dp_add_c)
    );

    fmaw_merge #(
        .ELEM_W (ELEM_W),
        .REG_W  (REG_W),
        .MAXVL  (MAXVL),
        .FLAG_W (FLAG_W)
    ) u_merge (
        .legal     (legal),
        .mask_en   (mask_en),
        .mask_b0   (mask_b0),
        .zero_mode (zero_mode),
        .dst       (dst_in),
        .result    (dp_result),
        .flags_in  (dp_flags),
        .wr_en     (wr_en_d),
        .data      (data_d),
        .flags_out (flags_d)
    );

    // Register the writeback slot; idle cycles clear it.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_valid  <= 1'b0;
            wr_en      <= 1'b0;
            wr_data    <= '0;
            illegal_op <= 1'b0;
            exc_flags  <= '0;
        end else begin
            out_valid  <= 1'b1;
            wr_en      <= wr_en_d;
            wr_data    <= data_d;
            illegal_op <= !legal;
            exc_flags  <= flags_d;
        end
    end
endmodule

// File: rtl/fma_route_wb_chk.sv
// Checker: temporal properties of the router, bound to the top module.
module fma_route_wb_chk #(
    parameter int OPC_W  = 8,
    parameter int ELEM_W = 32,
    parameter int REG_W  = 128,
    parameter int MAXVL  = 512,
    parameter int FLAG_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OPC_W-1:0]  opcode,
    input logic [REG_W-1:0]  dst_in,
    input logic [REG_W-1:0]  src2_in,
    input logic [ELEM_W-1:0] src3_in,
    input logic              mask_en,
    input logic              mask_b0,
    input logic              zero_mode,
    input logic [ELEM_W-1:0] dp_mul_a,
    input logic [ELEM_W-1:0] dp_mul_b,
    input logic [ELEM_W-1:0] dp_add_c,
    input logic              out_valid,
    input logic              wr_en,
    input logic [MAXVL-1:0]  wr_data,
    input logic              illegal_op,
    input logic [FLAG_W-1:0] exc_flags
);
    assert_route_132_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 8'h99) |-> (dp_mul_a == dst_in[ELEM_W-1:0] &&
                               dp_mul_b == src3_in &&
                               dp_add_c == src2_in[ELEM_W-1:0]));

    assert_route_231_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 8'hB9) |-> (dp_mul_a == src2_in[ELEM_W-1:0] &&
                               dp_mul_b == src3_in &&
                               dp_add_c == dst_in[ELEM_W-1:0]));

    assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid)));

    assert_keep_mid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (illegal_op || wr_data[REG_W-1:ELEM_W] == $past(dst_in[REG_W-1:ELEM_W])));

    assert_zero_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en && !mask_b0 && zero_mode) |=> (wr_data[ELEM_W-1:0] == '0));

    assert_merge_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en && !mask_b0 && !zero_mode) |=>
            (illegal_op || wr_data[ELEM_W-1:0] == $past(dst_in[ELEM_W-1:0])));

    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data[MAXVL-1:REG_W] == '0);

    assert_illegal_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> (!wr_en && out_valid));

    assert_flags_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en && !mask_b0) |=> (exc_flags == '0));
endmodule

bind fma_route_wb fma_route_wb_chk #(
    .OPC_W  (OPC_W),
    .ELEM_W (ELEM_W),
    .REG_W  (REG_W),
    .MAXVL  (MAXVL),
    .FLAG_W (FLAG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .opcode     (opcode),
    .dst_in     (dst_in),
    .src2_in    (src2_in),
    .src3_in    (src3_in),
    .mask_en    (mask_en),
    .mask_b0    (mask_b0),
    .zero_mode  (zero_mode),
    .dp_mul_a   (dp_mul_a),
    .dp_mul_b   (dp_mul_b),
    .dp_add_c   (dp_add_c),
    .out_valid  (out_valid),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .illegal_op (illegal_op),
    .exc_flags  (exc_flags)
);

// File: tb/fma_route_wb_tb_top.sv
// Bench: vector table walked by one loop, then directed reset/idle tests.
module fma_route_wb_tb_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [7:0]   opcode;
    logic [127:0] dst_in, src2_in;
    logic [31:0]  src3_in;
    logic         mask_en, mask_b0, zero_mode;
    logic [31:0]  dp_mul_a, dp_mul_b, dp_add_c, dp_result;
    logic [4:0]   dp_flags;
    logic         out_valid, wr_en, illegal_op;
    logic [511:0] wr_data;
    logic [4:0]   exc_flags;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;  // 125 MHz

    // Datapath stand-in: asymmetric function so routing errors show up.
    function automatic logic [31:0] dp_fn(logic [31:0] a, b, c);
        return a * 32'd3 + b * 32'd5 + c * 32'd7 + 32'h1357_9BDF;
    endfunction
    function automatic logic [4:0] fl_fn(logic [31:0] a, b, c);
        return (a[4:0] ^ {b[3:0], 1'b1} ^ c[9:5]) | 5'b00001;
    endfunction

    always_comb dp_result = dp_fn(dp_mul_a, dp_mul_b, dp_add_c);
    always_comb dp_flags  = fl_fn(dp_mul_a, dp_mul_b, dp_add_c);

    fma_route_wb dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .dst_in(dst_in), .src2_in(src2_in), .src3_in(src3_in),
        .mask_en(mask_en), .mask_b0(mask_b0), .zero_mode(zero_mode),
        .dp_mul_a(dp_mul_a), .dp_mul_b(dp_mul_b), .dp_add_c(dp_add_c),
        .dp_result(dp_result), .dp_flags(dp_flags),
        .out_valid(out_valid), .wr_en(wr_en), .wr_data(wr_data),
        .illegal_op(illegal_op), .exc_flags(exc_flags)
    );

    typedef struct packed {
        logic [7:0]   opc;
        logic [127:0] dst;
        logic [127:0] s2;
        logic [31:0]  s3;
        logic         men;
        logic         mb0;
        logic         zm;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h99, 128'h0123_4567_89AB_CDEF_1111_2222_3F80_0000, 128'hAAAA_BBBB_CCCC_DDDD_EEEE_FFFF_4000_0000, 32'h4040_0000, 1'b0, 1'b0, 1'b0},
        '{8'hA9, 128'hFEDC_BA98_7654_3210_0F0F_0F0F_1234_5678, 128'h1357_2468_ACE0_BDF1_5555_6666_0000_0077, 32'h8765_4321, 1'b0, 1'b1, 1'b1},
        '{8'hB9, 128'h1111_1111_2222_2222_3333_3333_4444_4444, 128'h9999_8888_7777_6666_5555_4444_0BAD_F00D, 32'hCAFE_0001, 1'b0, 1'b0, 1'b0},
        '{8'h99, 128'hDEAD_BEEF_0000_1111_2222_3333_0102_0304, 128'h0000_0000_0000_0000_0000_0000_0A0B_0C0D, 32'h1020_3040, 1'b1, 1'b1, 1'b1},
        '{8'hA9, 128'h7777_6666_5555_4444_3333_2222_ABCD_EF01, 128'h0101_0101_0202_0202_0303_0303_0404_0404, 32'h0606_0606, 1'b1, 1'b0, 1'b0},
        '{8'hB9, 128'h8888_9999_AAAA_BBBB_CCCC_DDDD_EEEE_FFFF, 128'h1234_1234_1234_1234_1234_1234_5678_5678, 32'h9ABC_9ABC, 1'b1, 1'b0, 1'b1},
        '{8'h98, 128'h5A5A_5A5A_A5A5_A5A5_5A5A_5A5A_A5A5_A5A5, 128'hFFFF_0000_FFFF_0000_FFFF_0000_FFFF_0000, 32'h0000_FFFF, 1'b0, 1'b0, 1'b0},
        '{8'hB9, 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0, 128'h0000_1111_2222_3333_4444_5555_6666_7777, 32'h7FFF_FFFF, 1'b0, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_idle();
        in_valid = 1'b0; opcode = 8'h00; dst_in = '0; src2_in = '0; src3_in = '0;
        mask_en = 1'b0; mask_b0 = 1'b0; zero_mode = 1'b0;
    endtask

    task automatic drive_vec(input vec_t v);
        in_valid = 1'b1; opcode = v.opc; dst_in = v.dst; src2_in = v.s2; src3_in = v.s3;
        mask_en = v.men; mask_b0 = v.mb0; zero_mode = v.zm;
    endtask

    initial begin
        rst_n = 1'b0;
        drive_idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 reset valid/wr/illegal", {509'd0, out_valid, wr_en, illegal_op}, '0);
        chk("R11 reset data", wr_data, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [31:0] ea, eb, ec, eres, elow;
            logic [4:0]  eflg;
            logic        legal, comp;
            v = VECS[i];
            @(negedge clk);
            drive_vec(v);
            #1;
            legal = 1'b1;
            case (v.opc)
                8'h99:   begin ea = v.dst[31:0]; eb = v.s3;        ec = v.s2[31:0]; end
                8'hA9:   begin ea = v.s2[31:0];  eb = v.dst[31:0]; ec = v.s3;       end
                8'hB9:   begin ea = v.s2[31:0];  eb = v.s3;        ec = v.dst[31:0]; end
                default: begin ea = '0; eb = '0; ec = '0; legal = 1'b0; end
            endcase
            // R1 / R2 / R3 routing, R9 zero operands when illegal
            chk($sformatf("R1/R2/R3/R9 routing vec%0d", i),
                {416'd0, dp_mul_a, dp_mul_b, dp_add_c}, {416'd0, ea, eb, ec});
            eres = dp_fn(ea, eb, ec);
            eflg = fl_fn(ea, eb, ec);
            comp = legal && (!v.men || v.mb0);
            elow = comp ? eres : (v.zm ? 32'd0 : v.dst[31:0]);
            @(negedge clk);
            drive_idle();
            chk($sformatf("R4/R9 valid,wr,illegal vec%0d", i),
                {509'd0, out_valid, wr_en, illegal_op}, {509'd0, 1'b1, legal, !legal});
            if (legal) begin
                chk($sformatf("R4/R5/R6 low element vec%0d", i), {480'd0, wr_data[31:0]}, {480'd0, elow});
                chk($sformatf("R7 bits 127:32 vec%0d", i), {416'd0, wr_data[127:32]}, {416'd0, v.dst[127:32]});
            end else begin
                chk($sformatf("R9 data zero vec%0d", i), wr_data, '0);
            end
            chk($sformatf("R8 upper zero vec%0d", i), {128'd0, wr_data[511:128]}, '0);
            chk($sformatf("R10 flags vec%0d", i), {507'd0, exc_flags}, {507'd0, comp ? eflg : 5'd0});
        end

        // R12: idle cycle after a request clears the slot
        @(negedge clk);
        chk("R12 idle outputs", {wr_data[511:8], out_valid, wr_en, illegal_op, exc_flags}, '0);

        // R11: reset wins over a pending request
        @(negedge clk);
        drive_vec(VECS[0]);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 reset over request", {wr_data[511:8], out_valid, wr_en, illegal_op, exc_flags}, '0);
        rst_n = 1'b1;
        drive_idle();

        // R4: back-to-back requests, second result follows first by one cycle
        @(negedge clk);
        drive_vec(VECS[2]);
        @(negedge clk);
        drive_vec(VECS[0]);
        @(negedge clk);
        drive_idle();
        chk("R4 back-to-back second low", {480'd0, wr_data[31:0]},
            {480'd0, dp_fn(VECS[0].dst[31:0], VECS[0].s3, VECS[0].s2[31:0])});

        @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule